// File: doc/BRIEF.md
# DDR SDRAM Command Pin Sequencer

This block sits between a memory controller and the command pins of a DDR SDRAM device. On each memory clock it turns one abstract command, offered over a valid/ready handshake, into the levels of clock enable, chip select, the three strobes (RAS#, CAS#, WE#), the bank address and the address bus. The auto-precharge flag is carried on address line 10. Every pin is registered, so an accepted command appears on the pins one clock after the handshake. When nothing is accepted, the block drives an idle pattern.

The block keeps the previous clock-enable level and a device power state (active, power-down, self-refresh). Entering or leaving a low-power state is therefore encoded as a change of clock enable between two cycles. While the device sleeps, only the matching exit command is taken. A mode-register write to bank 0 with address bit 8 low releases the DLL reset. Reads, writes and activates are then refused for a fixed number of clocks. They are also refused from reset until the first such release.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset the pins read CKE=1, CS#=RAS#=CAS#=WE#=1, bank and address buses 0. The power state is 0 (active), and read, write and activate commands are refused (ready low) until a DLL release wait has completed.
- R2: Command codes on the 4-bit command input are 0 NOP, 1 deselect, 2 read, 3 read+AP, 4 write, 5 write+AP, 6 activate, 7 precharge bank, 8 precharge all, 9 auto refresh, 10 self-refresh enter, 11 self-refresh exit, 12 power-down enter, 13 power-down exit, 14 mode register write, and 15 reserved. An accepted command appears on the pins one cycle later. In a cycle with no accepted command and CKE high, the pins show NOP: CKE=1, CS#=0, RAS#=CAS#=WE#=1, buses 0.
- R3: Read and read+AP drive CS#=0, RAS#=1, CAS#=0, WE#=1. The bank bus carries the request bank and the address bus carries the request address, with bit 10 forced to 0 for read and to 1 for read+AP.
- R4: Write and write+AP use the read pattern but with WE#=0, and force address bit 10 in the same way.
- R5: Activate drives CS#=0, RAS#=0, CAS#=1, WE#=1 and passes the bank and the full request address through unchanged.
- R6: Precharge drives CS#=0, RAS#=0, CAS#=1, WE#=0. The bank form drives the request bank and an all-zero address. The all-banks form drives bank 0 and an address with only bit 10 set.
- R7: Auto refresh drives CS#=0, RAS#=0, CAS#=0, WE#=1 with CKE high in that cycle and the next, and zero buses. A mode register write drives all four strobes low and passes the bank and address through.
- R8: Deselect drives CS#=1, the strobes 1, the buses 0 and CKE=1.
- R9: Power-down entry drives CKE=0 with CS# and the strobes high, and sets power state 1. Idle cycles in power-down keep CKE=0 and CS#=1. Power-down exit drives CKE=1 with CS#=1 and returns the state to 0.
- R10: Self-refresh entry drives CKE=0 with the auto-refresh strobe pattern and sets power state 2. Self-refresh exit drives CKE=1 with CS#=1 and returns the state to 0.
- R11: In power-down only power-down exit is accepted, and in self-refresh only self-refresh exit is accepted. In the active state both exits and code 15 are refused.
- R12: A mode register write to bank 0 with address bit 8 low starts a wait. Read, read+AP, write, write+AP and activate are refused for exactly DLL_WAIT clock edges following the accepting edge. A write to bank 0 with bit 8 high refuses them again until the next release completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered |
| req_cmd | input | 4 | Command code |
| req_bank | input | BANK_W | Bank for the command |
| req_addr | input | ADDR_W | Row, column or mode value |
| req_ready | output | 1 | Command can be accepted this cycle |
| ck_en | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address pins |
| ma | output | ADDR_W | Address pins |
| dev_state | output | 2 | Power state: 0 active, 1 power-down, 2 self-refresh |

## Verification
The bench builds the block with a 14-bit address, a 2-bit bank bus, the auto-precharge flag on bit 10, the DLL flag on bit 8 and DLL_WAIT set to 16. The shorter wait lets the bench hold a read against the gate and count the refused cycles one by one. It then confirms the exact boundary in both directions, as well as the re-closing caused by a DLL reset write. The address values are chosen so that bit 10 is set in some and clear in others, which exposes the forcing of the auto-precharge line.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP       = 4'd0,
        CMD_DESEL     = 4'd1,
        CMD_READ      = 4'd2,
        CMD_READ_AP   = 4'd3,
        CMD_WRITE     = 4'd4,
        CMD_WRITE_AP  = 4'd5,
        CMD_ACT       = 4'd6,
        CMD_PRE       = 4'd7,
        CMD_PRE_ALL   = 4'd8,
        CMD_REF       = 4'd9,
        CMD_SREF_IN   = 4'd10,
        CMD_SREF_OUT  = 4'd11,
        CMD_PD_IN     = 4'd12,
        CMD_PD_OUT    = 4'd13,
        CMD_MODE      = 4'd14,
        CMD_RSVD      = 4'd15
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_PDOWN  = 2'd1,
        PWR_SREF   = 2'd2
    } pwr_e;

    // Commands that touch rows or columns and must wait for the DLL
    function automatic logic is_access(cmd_e c);
        return (c == CMD_READ) || (c == CMD_READ_AP) || (c == CMD_WRITE) ||
               (c == CMD_WRITE_AP) || (c == CMD_ACT);
    endfunction

endpackage

// File: rtl/ddr_pin_encode.sv
module ddr_pin_encode
    import ddr_cmd_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  cmd_e              cmd,
    input  logic              cke_prev,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] ma
);
    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    always_comb begin
        cke   = 1'b1;
        cs_n  = 1'b1;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        ma    = '0;
        case (cmd)
            CMD_NOP: begin
                if (cke_prev) cs_n = 1'b0;
                else          cke  = 1'b0;
            end
            CMD_READ, CMD_READ_AP, CMD_WRITE, CMD_WRITE_AP: begin
                cs_n  = 1'b0;
                cas_n = 1'b0;
                we_n  = !((cmd == CMD_WRITE) || (cmd == CMD_WRITE_AP));
                ba    = bank;
                ma    = ((cmd == CMD_READ_AP) || (cmd == CMD_WRITE_AP)) ?
                        (addr | AP_MASK) : (addr & ~AP_MASK);
            end
            CMD_ACT: begin
                cs_n  = 1'b0;
                ras_n = 1'b0;
                ba    = bank;
                ma    = addr;
            end
            CMD_PRE: begin
                cs_n  = 1'b0;
                ras_n = 1'b0;
                we_n  = 1'b0;
                ba    = bank;
            end
            CMD_PRE_ALL: begin
                cs_n  = 1'b0;
                ras_n = 1'b0;
                we_n  = 1'b0;
                ma    = AP_MASK;
            end
            CMD_REF, CMD_SREF_IN: begin
                cke   = (cmd == CMD_REF);
                cs_n  = 1'b0;
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_PD_IN: cke = 1'b0;
            CMD_MODE: begin
                cs_n  = 1'b0;
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = bank;
                ma    = addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_pwr_track.sv
module ddr_pwr_track
    import ddr_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  cmd_e cmd,
    output pwr_e state_q
);
    pwr_e state_d;

    always_comb begin
        state_d = state_q;
        if (fire) begin
            case (cmd)
                CMD_PD_IN:                 state_d = PWR_PDOWN;
                CMD_SREF_IN:               state_d = PWR_SREF;
                CMD_PD_OUT, CMD_SREF_OUT:  state_d = PWR_ACTIVE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_ACTIVE;
        else        state_q <= state_d;
    end

    // R11
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PWR_ACTIVE && state_d == PWR_ACTIVE) |->
        (fire && (cmd == (state_q == PWR_PDOWN ? CMD_PD_OUT : CMD_SREF_OUT))));
endmodule

// File: rtl/ddr_dll_gate.sv
module ddr_dll_gate #(
    parameter int DLL_WAIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_fire,
    input  logic mode_bank0,
    input  logic dll_flag,
    output logic open
);
    localparam int CNT_W = $clog2(DLL_WAIT + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  hit;

    assign hit  = mode_fire && mode_bank0;
    assign open = gate_q.armed && (gate_q.cnt == '0);

    always_comb begin
        gate_d = gate_q;
        if (hit) begin
            gate_d.armed = !dll_flag;
            gate_d.cnt   = CNT_W'(DLL_WAIT);
        end else if (gate_q.cnt != '0) begin
            gate_d.cnt = gate_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '{armed: 1'b0, cnt: '0};
        else        gate_q <= gate_d;
    end

    // R12
    wait_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.cnt != '0 && !hit) |=> (gate_q.cnt == $past(gate_q.cnt) - 1'b1));

    // R12
    release_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !open);
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
    import ddr_cmd_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int BANK_W   = 2,
    parameter int AP_BIT   = 10,
    parameter int DLL_BIT  = 8,
    parameter int DLL_WAIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              ck_en,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] ma,
    output logic [1:0]        dev_state
);
    typedef struct packed {
        logic              cke;
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] ma;
    } pins_t;

    pins_t pins_d, pins_q;
    cmd_e  cmd_in, sel_cmd;
    pwr_e  pwr_q;
    logic  fire, gate_open;

    assign cmd_in  = cmd_e'(req_cmd);
    assign fire    = req_valid && req_ready;
    assign sel_cmd = fire ? cmd_in : CMD_NOP;

    always_comb begin
        req_ready = 1'b0;
        case (pwr_q)
            PWR_ACTIVE: begin
                case (cmd_in)
                    CMD_PD_OUT, CMD_SREF_OUT, CMD_RSVD: req_ready = 1'b0;
                    default: req_ready = !is_access(cmd_in) || gate_open;
                endcase
            end
            PWR_PDOWN: req_ready = (cmd_in == CMD_PD_OUT);
            PWR_SREF:  req_ready = (cmd_in == CMD_SREF_OUT);
            default:   req_ready = 1'b0;
        endcase
    end

    ddr_pin_encode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)) u_enc (
        .cmd(sel_cmd), .cke_prev(pins_q.cke), .bank(req_bank), .addr(req_addr),
        .cke(pins_d.cke), .cs_n(pins_d.cs_n), .ras_n(pins_d.ras_n),
        .cas_n(pins_d.cas_n), .we_n(pins_d.we_n), .ba(pins_d.ba), .ma(pins_d.ma)
    );

    ddr_pwr_track u_pwr (
        .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cmd_in), .state_q(pwr_q)
    );

    ddr_dll_gate #(.DLL_WAIT(DLL_WAIT)) u_gate (
        .clk(clk), .rst_n(rst_n), .mode_fire(fire && cmd_in == CMD_MODE),
        .mode_bank0(req_bank == '0), .dll_flag(req_addr[DLL_BIT]), .open(gate_open)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                we_n: 1'b1, ba: '0, ma: '0};
        else        pins_q <= pins_d;
    end

    assign ck_en     = pins_q.cke;
    assign cs_n      = pins_q.cs_n;
    assign ras_n     = pins_q.ras_n;
    assign cas_n     = pins_q.cas_n;
    assign we_n      = pins_q.we_n;
    assign ba        = pins_q.ba;
    assign ma        = pins_q.ma;
    assign dev_state = pwr_q;

    // R9
    sleep_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q != PWR_ACTIVE) |-> !ck_en);

    // R9
    wake_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ck_en) |-> cs_n);

    // R12
    access_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_access(cmd_in)) |-> gate_open);

    // R3
    read_ap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_in == CMD_READ) |=> (!ma[AP_BIT] && !cs_n && !cas_n && we_n));

    // R11
    pdown_only_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q == PWR_PDOWN && req_ready) |-> (cmd_in == CMD_PD_OUT));
endmodule

// File: tb/ddr_cmd_seq_tb.sv
module ddr_cmd_seq_tb;
    import ddr_cmd_pkg::*;

    localparam int AW = 14;
    localparam int BW = 2;
    localparam int W  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_cmd = '0;
    logic [BW-1:0] req_bank = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, ck_en, cs_n, ras_n, cas_n, we_n;
    logic [BW-1:0] ba;
    logic [AW-1:0] ma;
    logic [1:0]    dev_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ddr_cmd_seq #(.ADDR_W(AW), .BANK_W(BW), .AP_BIT(10), .DLL_BIT(8), .DLL_WAIT(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready),
        .ck_en(ck_en), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .ma(ma), .dev_state(dev_state)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag, input logic [4:0] ctl,
                            input int bv, input int mv, input int st);
        chk({ck_en, cs_n, ras_n, cas_n, we_n} == ctl, tag, "cke/cs/ras/cas/we",
            {ck_en, cs_n, ras_n, cas_n, we_n}, ctl);
        chk(ba == bv[BW-1:0], tag, "ba", ba, bv);
        chk(ma == mv[AW-1:0], tag, "ma", ma, mv);
        chk(dev_state == st[1:0], tag, "state", dev_state, st);
    endtask

    task automatic issue(input cmd_e c, input int b, input int a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = b[BW-1:0]; req_addr = a[AW-1:0];
        #1 chk(req_ready == 1'b1, tag, "ready", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cmd = '0;
    endtask

    task automatic refuse(input cmd_e c, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = '0; req_addr = '0;
        #1 chk(req_ready == 1'b0, tag, "ready refused", req_ready, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cmd = '0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_pins("R1 reset", 5'b11111, 0, 0, 0);
        req_valid = 1'b1; req_cmd = CMD_READ;
        #1 chk(req_ready == 1'b0, "R1", "read ready after reset", req_ready, 0);
        req_valid = 1'b0; req_cmd = '0;
        @(negedge clk);
        chk_pins("R2 idle nop", 5'b10111, 0, 0, 0);
    endtask

    task automatic t_dll();
        int lows = 0;
        issue(CMD_MODE, 0, 'h0100, "R7 mode dll reset");
        chk_pins("R7 mode", 5'b10000, 0, 'h0100, 0);
        issue(CMD_MODE, 1, 'h0000, "R7 ext mode");
        chk_pins("R7 ext mode", 5'b10000, 1, 0, 0);
        refuse(CMD_ACT, "R12 closed before release");
        @(negedge clk);
        req_valid = 1'b1; req_cmd = CMD_MODE; req_bank = '0; req_addr = 'h0032;
        @(posedge clk);
        @(negedge clk);
        req_cmd = CMD_READ; req_bank = 2; req_addr = 'h0455;
        #1;
        while (!req_ready && lows < 4 * W) begin
            lows++;
            @(posedge clk);
            @(negedge clk);
            #1;
        end
        chk(lows == W, "R12", "refused cycles after release", lows, W);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cmd = '0;
        chk_pins("R3 read", 5'b10101, 2, 'h0055, 0);
    endtask

    task automatic t_access();
        issue(CMD_READ_AP, 1, 'h0055, "R3 read ap");
        chk_pins("R3 read ap", 5'b10101, 1, 'h0455, 0);
        issue(CMD_WRITE, 3, 'h3FFF, "R4 write");
        chk_pins("R4 write", 5'b10100, 3, 'h3BFF, 0);
        issue(CMD_WRITE_AP, 0, 'h0001, "R4 write ap");
        chk_pins("R4 write ap", 5'b10100, 0, 'h0401, 0);
        issue(CMD_ACT, 2, 'h2ABC, "R5 act");
        chk_pins("R5 act", 5'b10011, 2, 'h2ABC, 0);
        issue(CMD_PRE, 3, 'h3FFF, "R6 pre");
        chk_pins("R6 pre", 5'b10010, 3, 0, 0);
        issue(CMD_PRE_ALL, 3, 'h3FFF, "R6 pre all");
        chk_pins("R6 pre all", 5'b10010, 0, 'h0400, 0);
        issue(CMD_REF, 2, 'h1234, "R7 refresh");
        chk_pins("R7 refresh", 5'b10001, 0, 0, 0);
        @(negedge clk);
        chk(ck_en == 1'b1, "R7", "cke after refresh", ck_en, 1);
        issue(CMD_DESEL, 1, 'h00FF, "R8 deselect");
        chk_pins("R8 deselect", 5'b11111, 0, 0, 0);
        refuse(CMD_PD_OUT, "R11 pd exit in active");
        refuse(CMD_SREF_OUT, "R11 sref exit in active");
        refuse(CMD_RSVD, "R11 reserved code");
        chk_pins("R2 nop after refusals", 5'b10111, 0, 0, 0);
    endtask

    task automatic t_pdown();
        issue(CMD_PD_IN, 0, 0, "R9 pd enter");
        chk_pins("R9 pd enter", 5'b01111, 0, 0, 1);
        @(negedge clk);
        chk_pins("R9 pd hold", 5'b01111, 0, 0, 1);
        refuse(CMD_READ, "R11 read in pd");
        refuse(CMD_NOP, "R11 nop in pd");
        refuse(CMD_SREF_OUT, "R11 sref exit in pd");
        refuse(CMD_PD_IN, "R11 pd enter in pd");
        chk_pins("R9 pd after refusals", 5'b01111, 0, 0, 1);
        issue(CMD_PD_OUT, 0, 0, "R9 pd exit");
        chk_pins("R9 pd exit", 5'b11111, 0, 0, 0);
        @(negedge clk);
        chk_pins("R2 nop after wake", 5'b10111, 0, 0, 0);
    endtask

    task automatic t_sref();
        issue(CMD_SREF_IN, 1, 'h0FF, "R10 sref enter");
        chk_pins("R10 sref enter", 5'b00001, 0, 0, 2);
        refuse(CMD_PD_OUT, "R11 pd exit in sref");
        refuse(CMD_REF, "R11 refresh in sref");
        chk_pins("R10 sref hold", 5'b01111, 0, 0, 2);
        issue(CMD_SREF_OUT, 0, 0, "R10 sref exit");
        chk_pins("R10 sref exit", 5'b11111, 0, 0, 0);
        issue(CMD_WRITE, 1, 'h0010, "R12 gate kept across sleep");
        chk_pins("R4 write after sleep", 5'b10100, 1, 'h0010, 0);
    endtask

    task automatic t_reclose();
        issue(CMD_MODE, 0, 'h0100, "R12 dll reset again");
        refuse(CMD_WRITE_AP, "R12 closed by dll reset");
        refuse(CMD_READ, "R12 still closed");
    endtask

    initial begin
        t_reset();
        t_dll();
        t_access();
        t_pdown();
        t_sref();
        t_reclose();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule